// File: doc/BRIEF.md
# Floppy Head Seek Controller

This block moves the read/write head of a floppy drive onto a requested track and reports when the drive is ready to transfer. After reset it drives the head outward one step at a time until the track-zero switch closes. That position becomes track 0. From then on the block knows where the head is only by counting the step pulses it has issued. It keeps no other position reference.

A seek request carries a target track from 0 to 76. The block issues step pulses with the correct direction until its internal track count matches the target. It then lets the head settle, lowers the head, and waits for the drive's head-loaded acknowledge to stay high for a fixed number of clocks. Finally it waits for the next start of a revolution, marked by the index pulse, before it reports done. A separate strobe marks the start of every revolution at all times.

Top module: `head_seek_ctrl`

## Requirements
- R1: After reset, busy is high and step, head-load and done are low. While track-zero is low, the block issues outward pulses (direction 0). It checks track-zero before each pulse and goes idle with current track 0 once track-zero is high, so no pulse is issued if track-zero is already high.
- R2: If track-zero is still low after 80 outward pulses, restore_err rises and busy falls. restore_err stays high and seek requests are ignored until the next reset.
- R3: An accepted seek issues exactly |target - current| pulses. Direction is 1 (inward, toward higher tracks) when the target is above the current track and 0 otherwise. The current track then equals the target.
- R4: Each step pulse is high for STEP_HI clocks, and direction does not change while it is high. From a pulse's fall to the next rise, step stays low for at least STEP_GAP clocks (exactly STEP_GAP+2 in this design).
- R5: After the last pulse of a seek, head-load rises STEP_GAP+2+SETTLE_CLKS clocks after step fell.
- R6: A seek to the current track issues no pulse and skips the settle wait. Head-load rises two clocks after the request is sampled.
- R7: Head-load is high from the end of motion until done. The load delay ends after LOAD_CLKS consecutive clocks with the acknowledge high. Any low acknowledge restarts the count, and no step occurs while head-load is high.
- R8: After the load delay, the block waits for a start-of-track strobe. In the clock after it sees the strobe, done is high for one cycle, and busy and head-load fall.
- R9: sot_o is a one-cycle pulse in the clock after the index input is first sampled high. It does not depend on the seek state.
- R10: A request with a target above 76 sets range_err, causes no motion and leaves the block idle. The next accepted request clears range_err.
- R11: Seek requests that arrive while busy is high are ignored.
- R12: busy is high from reset through restore and through every seek until done, and low only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seek_req_i | input | 1 | One-cycle seek request |
| target_i | input | TRK_W | Requested track, sampled with seek_req_i |
| trk0_i | input | 1 | Track-zero switch, high at the outermost track |
| index_i | input | 1 | Index pulse, once per revolution |
| head_ack_i | input | 1 | Drive acknowledge that the head is down |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction, 1 inward, 0 outward |
| head_load_o | output | 1 | Request to lower the head |
| busy_o | output | 1 | Restore or seek in progress |
| done_o | output | 1 | One-cycle ready-for-transfer pulse |
| sot_o | output | 1 | Start-of-track strobe |
| range_err_o | output | 1 | Last request named a track beyond 76 |
| restore_err_o | output | 1 | Track zero was not found during restore |

## Verification
The assertions assume that every input is synchronous to the clock. They also assume that the index input stays high for more than one clock, so each revolution gives exactly one strobe. The acknowledge is assumed to move only while head-load is high. The stimulus drives all inputs just after the falling edge. A drive model derives track-zero from a physical head position that moves on every step pulse. The acknowledge is raised a set number of clocks after head-load and dropped for one clock in one test. Index pulses arrive every 250 clocks and stay high for 4 clocks.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  typedef enum logic [2:0] {
    SK_RCHK,
    SK_RWAIT,
    SK_IDLE,
    SK_MOVE,
    SK_SWAIT,
    SK_SETTLE,
    SK_LOAD,
    SK_ALIGN
  } seek_st_t;
endpackage

// File: rtl/hs_rst_sync.sv
`timescale 1ns/1ps
module hs_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      rst_no <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_no <= meta_q;
    end
  end
endmodule

// File: rtl/hs_step_pulser.sv
`timescale 1ns/1ps
module hs_step_pulser #(
  parameter int HI_CLKS  = 4,
  parameter int GAP_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic dir_i,
  output logic step_o,
  output logic dir_o,
  output logic active_o
);
  localparam int MAXC = (HI_CLKS > GAP_CLKS) ? HI_CLKS : GAP_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic          step_q, step_n;
  logic          act_q, act_n;
  logic          dir_q, dir_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    step_n = step_q;
    act_n  = act_q;
    dir_n  = dir_q;
    cnt_n  = cnt_q;
    if (fire_i) begin
      step_n = 1'b1;
      act_n  = 1'b1;
      dir_n  = dir_i;
      cnt_n  = CW'(HI_CLKS - 1);
    end else if (act_q) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - CW'(1);
      end else if (step_q) begin
        step_n = 1'b0;
        cnt_n  = CW'(GAP_CLKS - 1);
      end else begin
        act_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      step_q <= step_n;
      act_q  <= act_n;
      dir_q  <= dir_n;
      cnt_q  <= cnt_n;
    end
  end

  assign step_o   = step_q;
  assign dir_o    = dir_q;
  assign active_o = act_q;
endmodule

// File: rtl/hs_index_strobe.sv
`timescale 1ns/1ps
module hs_index_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  output logic sot_o
);
  logic prev_q, sot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      sot_q  <= 1'b0;
    end else begin
      prev_q <= index_i;
      sot_q  <= index_i & ~prev_q;
    end
  end

  assign sot_o = sot_q;
endmodule

// File: rtl/head_seek_ctrl.sv
`timescale 1ns/1ps
module head_seek_ctrl
  import hs_pkg::*;
#(
  parameter int TRACKS      = 77,
  parameter int TRK_W       = $clog2(TRACKS),
  parameter int STEP_HI     = 4,
  parameter int STEP_GAP    = 8,
  parameter int SETTLE_CLKS = 20,
  parameter int LOAD_CLKS   = 16,
  parameter int RESTORE_LIM = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seek_req_i,
  input  logic [TRK_W-1:0] target_i,
  input  logic             trk0_i,
  input  logic             index_i,
  input  logic             head_ack_i,
  output logic             step_o,
  output logic             dir_o,
  output logic             head_load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sot_o,
  output logic             range_err_o,
  output logic             restore_err_o
);
  localparam int TMR_MAX = (SETTLE_CLKS > LOAD_CLKS) ? SETTLE_CLKS : LOAD_CLKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int RC_W    = $clog2(RESTORE_LIM + 1);
  localparam logic [TRK_W-1:0] LAST_TRK = TRK_W'(TRACKS - 1);

  logic             rst_n;
  seek_st_t         st_q, st_n;
  logic [TRK_W-1:0] cur_q, cur_n, tgt_q, tgt_n;
  logic             moved_q, moved_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [RC_W-1:0]  rcnt_q, rcnt_n;
  logic             rerr_q, rerr_n, serr_q, serr_n, done_q, done_n;
  logic             fire, fire_dir, pulse_act, sot;

  hs_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  hs_step_pulser #(
    .HI_CLKS  (STEP_HI),
    .GAP_CLKS (STEP_GAP)
  ) u_pulser (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .fire_i   (fire),
    .dir_i    (fire_dir),
    .step_o   (step_o),
    .dir_o    (dir_o),
    .active_o (pulse_act)
  );

  hs_index_strobe u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .index_i (index_i),
    .sot_o   (sot)
  );

  always_comb begin
    st_n     = st_q;
    cur_n    = cur_q;
    tgt_n    = tgt_q;
    moved_n  = moved_q;
    tmr_n    = tmr_q;
    rcnt_n   = rcnt_q;
    rerr_n   = rerr_q;
    serr_n   = serr_q;
    done_n   = 1'b0;
    fire     = 1'b0;
    fire_dir = 1'b0;
    unique case (st_q)
      SK_RCHK: begin
        if (trk0_i) begin
          cur_n = '0;
          st_n  = SK_IDLE;
        end else if (rcnt_q == RC_W'(RESTORE_LIM)) begin
          rerr_n = 1'b1;
          st_n   = SK_IDLE;
        end else begin
          fire   = 1'b1;
          rcnt_n = rcnt_q + RC_W'(1);
          st_n   = SK_RWAIT;
        end
      end
      SK_RWAIT: if (!pulse_act) st_n = SK_RCHK;
      SK_IDLE: begin
        if (seek_req_i && !rerr_q) begin
          if (target_i > LAST_TRK) begin
            serr_n = 1'b1;
          end else begin
            serr_n  = 1'b0;
            tgt_n   = target_i;
            moved_n = 1'b0;
            st_n    = SK_MOVE;
          end
        end
      end
      SK_MOVE: begin
        tmr_n = '0;
        if (cur_q == tgt_q) begin
          st_n = moved_q ? SK_SETTLE : SK_LOAD;
        end else begin
          fire     = 1'b1;
          fire_dir = (tgt_q > cur_q);
          cur_n    = (tgt_q > cur_q) ? cur_q + TRK_W'(1) : cur_q - TRK_W'(1);
          moved_n  = 1'b1;
          st_n     = SK_SWAIT;
        end
      end
      SK_SWAIT: if (!pulse_act) st_n = SK_MOVE;
      SK_SETTLE: begin
        if (tmr_q == TMR_W'(SETTLE_CLKS - 1)) begin
          tmr_n = '0;
          st_n  = SK_LOAD;
        end else begin
          tmr_n = tmr_q + TMR_W'(1);
        end
      end
      SK_LOAD: begin
        if (!head_ack_i) begin
          tmr_n = '0;
        end else if (tmr_q == TMR_W'(LOAD_CLKS - 1)) begin
          tmr_n = '0;
          st_n  = SK_ALIGN;
        end else begin
          tmr_n = tmr_q + TMR_W'(1);
        end
      end
      SK_ALIGN: begin
        if (sot) begin
          done_n = 1'b1;
          st_n   = SK_IDLE;
        end
      end
      default: st_n = SK_RCHK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SK_RCHK;
      cur_q   <= '0;
      tgt_q   <= '0;
      moved_q <= 1'b0;
      tmr_q   <= '0;
      rcnt_q  <= '0;
      rerr_q  <= 1'b0;
      serr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      tgt_q   <= tgt_n;
      moved_q <= moved_n;
      tmr_q   <= tmr_n;
      rcnt_q  <= rcnt_n;
      rerr_q  <= rerr_n;
      serr_q  <= serr_n;
      done_q  <= done_n;
    end
  end

  assign busy_o        = (st_q != SK_IDLE);
  assign head_load_o   = (st_q == SK_LOAD) || (st_q == SK_ALIGN);
  assign done_o        = done_q;
  assign sot_o         = sot;
  assign range_err_o   = serr_q;
  assign restore_err_o = rerr_q;
endmodule

// File: rtl/hs_seek_chk.sv
`timescale 1ns/1ps
module hs_seek_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic index_i,
  input logic step_o,
  input logic dir_o,
  input logic head_load_o,
  input logic busy_o,
  input logic done_o,
  input logic sot_o,
  input logic range_err_o,
  input logic restore_err_o
);
  p_step_dir_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && $past(step_o)) |-> (dir_o == $past(dir_o)));

  p_step_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_o) |=> !step_o);

  p_step_only_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !step_o);

  p_no_step_loaded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_load_o |-> !step_o);

  p_done_after_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(head_load_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !head_load_o));

  p_sot_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sot_o) |-> ($past(index_i) && !$past(index_i, 2)));

  p_sot_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sot_o |=> !sot_o);

  p_range_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> !busy_o);

  p_restore_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_err_o |-> !busy_o);

  p_restore_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_err_o |=> restore_err_o);
endmodule

bind head_seek_ctrl hs_seek_chk u_hs_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .index_i       (index_i),
  .step_o        (step_o),
  .dir_o         (dir_o),
  .head_load_o   (head_load_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .sot_o         (sot_o),
  .range_err_o   (range_err_o),
  .restore_err_o (restore_err_o)
);

// File: tb/test_head_seek_ctrl.sv
`timescale 1ns/1ps
module test_head_seek_ctrl;
  localparam int TRK  = 77;
  localparam int HI   = 4;
  localparam int GAP  = 8;
  localparam int SET  = 20;
  localparam int LDL  = 16;
  localparam int RLIM = 80;
  localparam int IPER = 250;
  localparam int IHI  = 4;

  logic       clk = 1'b0;
  logic       rst_n, seek_req, index, head_ack;
  logic [6:0] target;
  logic       trk0;
  logic       step_o, dir_o, head_load_o, busy_o, done_o, sot_o, range_err_o, restore_err_o;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  int  phys = 0, steps = 0, ack_dly = 3, hl_cnt = 0;
  bit  broken = 0, glitch = 0, cmp_en = 0, finished = 0;
  bit  prev_step = 0, prev_hl = 0;
  int  fall_cyc = 0, rise_cyc = 0;

  // reference model state
  bit e_step, e_dir, e_busy, e_hl, e_done, e_sot, e_serr, e_rerr;
  bit h1, h2, sot_before, ab, m_rst;
  int m_cur;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign trk0 = (phys == 0) && !broken;

  head_seek_ctrl #(.TRACKS(TRK), .STEP_HI(HI), .STEP_GAP(GAP), .SETTLE_CLKS(SET),
                   .LOAD_CLKS(LDL), .RESTORE_LIM(RLIM)) i_head_seek_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .seek_req_i(seek_req), .target_i(target),
    .trk0_i(trk0), .index_i(index), .head_ack_i(head_ack),
    .step_o(step_o), .dir_o(dir_o), .head_load_o(head_load_o), .busy_o(busy_o),
    .done_o(done_o), .sot_o(sot_o), .range_err_o(range_err_o),
    .restore_err_o(restore_err_o));

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  task automatic set_reset_vals();
    e_step = 0; e_dir = 0; e_busy = 1; e_hl = 0; e_done = 0;
    e_sot = 0; e_serr = 0; e_rerr = 0; h1 = 0; h2 = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    e_done = 1'b0;
    sot_before = e_sot;
    h2 = h1;
    h1 = index;
    e_sot = h1 && !h2;
    if (m_rst) begin h1 = 0; h2 = 0; e_sot = 0; end
    ab = !rst_n;
    if (ab) set_reset_vals();
  endtask

  task automatic run_model();
    int n, c, tgt;
    bit moved;
    n = 0;
    m_cur = 0;
    forever begin                           // restore (R1, R2)
      tick(); if (ab) return;
      if (trk0) begin e_busy = 0; break; end
      if (n == RLIM) begin e_rerr = 1; e_busy = 0; break; end
      n++;
      e_step = 1; e_dir = 0;
      repeat (HI) begin tick(); if (ab) return; end
      e_step = 0;
      repeat (GAP + 1) begin tick(); if (ab) return; end
    end
    forever begin                           // idle
      tick(); if (ab) return;
      if (!seek_req || e_rerr) continue;
      if (int'(target) > TRK - 1) begin e_serr = 1; continue; end
      e_serr = 0; e_busy = 1; tgt = int'(target); moved = 0;
      forever begin                         // motion (R3, R4)
        tick(); if (ab) return;
        if (m_cur == tgt) break;
        e_step = 1; e_dir = (tgt > m_cur);
        m_cur += (tgt > m_cur) ? 1 : -1;
        moved = 1;
        repeat (HI) begin tick(); if (ab) return; end
        e_step = 0;
        repeat (GAP + 1) begin tick(); if (ab) return; end
      end
      if (moved) begin                      // settle (R5), skipped when still (R6)
        repeat (SET) begin tick(); if (ab) return; end
      end
      e_hl = 1;
      c = 0;
      forever begin                         // load delay (R7)
        tick(); if (ab) return;
        if (head_ack) begin
          c++;
          if (c == LDL) break;
        end else c = 0;
      end
      forever begin                         // index alignment (R8)
        tick(); if (ab) return;
        if (sot_before) begin e_done = 1; e_hl = 0; e_busy = 0; break; end
      end
    end
  endtask

  initial begin : model
    set_reset_vals();
    m_rst = 1;
    forever begin
      do tick(); while (!rst_n);
      tick();
      m_rst = 0;
      run_model();
      m_rst = 1;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      check("R4",  "step",        step_o,        e_step);
      check("R3",  "dir",         dir_o,         e_dir);
      check("R12", "busy",        busy_o,        e_busy);
      check("R7",  "head_load",   head_load_o,   e_hl);
      check("R8",  "done",        done_o,        e_done);
      check("R9",  "sot",         sot_o,         e_sot);
      check("R10", "range_err",   range_err_o,   e_serr);
      check("R2",  "restore_err", restore_err_o, e_rerr);
    end
  end

  // ---------------- drive model and monitors ----------------
  always @(negedge clk) begin
    if (step_o && !prev_step) begin
      steps++;
      if (dir_o) begin if (phys < TRK - 1) phys++; end
      else if (phys > 0) phys--;
    end
    if (prev_step && !step_o) fall_cyc = cyc;
    if (!prev_hl && head_load_o) rise_cyc = cyc;
    prev_step = step_o;
    prev_hl = head_load_o;
  end

  initial begin : ack_gen
    head_ack = 0;
    forever begin
      @(negedge clk); #1;
      if (head_load_o) begin
        hl_cnt++;
        head_ack = (hl_cnt >= ack_dly) && !(glitch && hl_cnt == ack_dly + 3);
      end else begin
        hl_cnt = 0;
        head_ack = 0;
      end
    end
  end

  initial begin : index_gen
    index = 0;
    forever begin
      repeat (IPER - IHI) @(negedge clk);
      #1 index = 1;
      repeat (IHI) @(negedge clk);
      #1 index = 0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  task automatic req_seek(int t);
    @(negedge clk); #1;
    seek_req = 1; target = 7'(t);
    @(negedge clk); #1;
    seek_req = 0;
  endtask

  task automatic wait_done(string req);
    int k = 0;
    while (!done_o && k < 6000) begin @(negedge clk); k++; end
    check(req, "done seen", done_o, 1);
    @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (busy_o && k < 6000) begin @(negedge clk); k++; end
    check(req, "idle reached", busy_o, 0);
  endtask

  initial begin : main
    rst_n = 0; seek_req = 0; target = '0;
    phys = 5;
    repeat (2) @(posedge clk);
    cmp_en = 1;
    @(negedge clk);
    check("R1", "reset busy", busy_o, 1);
    check("R1", "reset step", step_o, 0);
    check("R1", "reset head_load", head_load_o, 0);
    check("R1", "reset done", done_o, 0);
    #1 rst_n = 1;
    steps = 0;
    wait_idle("R1");
    check("R1", "restore position", phys, 0);
    check("R1", "restore pulses", steps, 5);

    steps = 0;
    req_seek(10);
    wait_done("R8");
    check("R3", "inward position", phys, 10);
    check("R3", "inward pulses", steps, 10);
    check("R5", "settle span", rise_cyc - fall_cyc, GAP + 2 + SET);

    steps = 0; ack_dly = 6;
    req_seek(3);
    wait_done("R8");
    check("R3", "outward position", phys, 3);
    check("R3", "outward pulses", steps, 7);

    steps = 0;
    req_seek(3);
    wait_done("R6");
    check("R6", "still seek pulses", steps, 0);

    steps = 0; glitch = 1;
    req_seek(76);
    wait_done("R7");
    glitch = 0;
    check("R3", "last track position", phys, 76);

    steps = 0;
    req_seek(77);
    repeat (10) @(negedge clk);
    check("R10", "range flag 77", range_err_o, 1);
    check("R10", "range no motion", steps + busy_o, 0);
    req_seek(120);
    repeat (10) @(negedge clk);
    check("R10", "range flag 120", range_err_o, 1);
    check("R10", "range position", phys, 76);

    steps = 0;
    req_seek(20);
    repeat (30) @(negedge clk);
    req_seek(0);
    wait_done("R11");
    repeat (300) @(negedge clk);
    check("R11", "ignored request position", phys, 20);
    check("R11", "ignored request idle", busy_o, 0);
    check("R10", "range cleared", range_err_o, 0);

    req_seek(0);
    wait_done("R8");
    check("R3", "home position", phys, 0);

    // restore failure
    @(negedge clk); #1 rst_n = 0;
    broken = 1; phys = 30; steps = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    wait_idle("R2");
    check("R2", "restore pulse limit", steps, RLIM);
    check("R2", "restore flag", restore_err_o, 1);
    steps = 0;
    req_seek(5);
    repeat (200) @(negedge clk);
    check("R2", "request after failure", steps + busy_o, 0);

    // restore with head already home
    @(negedge clk); #1 rst_n = 0;
    broken = 0; phys = 0; steps = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    wait_idle("R1");
    check("R1", "home at reset pulses", steps, 0);
    check("R2", "flag cleared by reset", restore_err_o, 0);

    steps = 0;
    req_seek(2);
    wait_done("R8");
    check("R3", "final position", phys, 2);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule